// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Entry Status Queue

This block turns an asynchronous serial line into characters of 5 to 9 data bits. An optional parity bit and one or two stop bits may follow the data. The line is watched on a baud tick that runs at 16 times the bit rate. A falling edge starts a candidate frame. Each bit, the start bit included, is decided by a majority vote over three ticks near the middle of the bit.

Every received character goes into a small first-in first-out queue together with its own flags:
- the ninth data bit,
- a frame error flag,
- a parity error flag,
- an overrun flag.

The consumer sees the oldest entry on the head outputs whenever `rx_avail` is high. It reads the ninth bit and the flags first, then pulses `rd_pop` to retire the entry and expose the next one.

The controlling state machine has six states:
- `ST_IDLE` waits for a falling edge and moves to `ST_START` (transition *edge seen*).
- `ST_START` returns to `ST_IDLE` if the mid-bit vote reads high (*glitch reject*). Otherwise it moves to `ST_DATA` at the end of the bit (*start confirmed*).
- `ST_DATA` stays put until the chosen number of bits has been shifted in. It then moves to `ST_PAR` when parity is on, or to `ST_STOP` when it is off (*data done*).
- `ST_PAR` moves to `ST_STOP` at the end of the parity bit (*parity done*).
- `ST_STOP` stores the frame at the mid-bit vote of the first stop bit. It then goes to `ST_IDLE` (*frame stored*), or to `ST_SKIP` when two stop bits are configured (*skip second stop*).
- `ST_SKIP` lets the rest of the first stop bit and the whole second stop bit pass unchecked, then returns to `ST_IDLE` (*skip done*).

Dropping the enable sends every state to `ST_IDLE` (*abort*).

Top module: `uart_rx_buffered`

## Requirements
- R1: While `rx_en` is low the line is ignored and nothing is stored. A frame during which `rx_en` falls is abandoned.
- R2: A falling edge on a tick starts a candidate frame. If the majority of the samples at ticks 8, 9 and 10 of the start bit (tick 0 being the edge) is high, the receiver returns to idle and stores nothing.
- R3: Data bits arrive least significant first, each decided by the majority of its ticks 8, 9 and 10. The length code `cfg_len` selects 5, 6, 7 or 8 bits for codes 0 to 3, and 9 bits for codes 4 to 7.
- R4: When fewer than 8 data bits are selected, the unused upper bits of `rx_data` read as zero.
- R5: In 9-bit mode the last data bit appears on `rx_bit8` of the same entry. In other modes `rx_bit8` is zero.
- R6: With `cfg_par_en` high, one parity bit follows the data. With `cfg_par_odd` = 0 the ones in data plus parity must be even, and with `cfg_par_odd` = 1 they must be odd. A mismatch sets `rx_perr`. With parity off, `rx_perr` stays 0.
- R7: A first stop bit that votes low sets `rx_ferr`, and the frame is still stored.
- R8: With `cfg_two_stop` high, the second stop bit is not checked, and a low second stop bit gives no frame error.
- R9: The queue holds 2 entries. `rx_avail` is high exactly when an entry is held. The head outputs hold still until `rd_pop`. A pop on an empty queue has no effect.
- R10: A frame that completes while the queue is full is discarded, and `rx_ovr` is set on the newest stored entry.
- R11: While the queue is empty, `rx_data`, `rx_bit8`, `rx_ferr`, `rx_perr` and `rx_ovr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx_line | input | 1 | Serial input, idle high, synchronous to clk |
| cfg_len | input | 3 | Character length code |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_two_stop | input | 1 | Two stop bits per frame |
| rd_pop | input | 1 | Retire the head entry |
| rx_avail | output | 1 | At least one entry held |
| rx_data | output | 8 | Head entry low data bits |
| rx_bit8 | output | 1 | Head entry ninth data bit |
| rx_ferr | output | 1 | Head entry frame error |
| rx_perr | output | 1 | Head entry parity error |
| rx_ovr | output | 1 | Head entry overrun |

## Verification
The properties assume the following about the inputs:
- The format inputs stay constant while any entry is held, so the masking and parity checks can be read against the current `cfg_len` and `cfg_par_en`.
- The enable is treated as settled once it has been low for two consecutive clocks.

The stimulus meets these assumptions in three ways. It changes the format only after the queue has been drained. It drops the enable only in the middle of data bits. It pulses `baud_tick` for one clock out of every two, and changes the line only together with a tick.

// File: rtl/urx_pkg.sv
package urx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_SKIP
    } urx_state_e;

    typedef struct packed {
        logic       ovr;
        logic       perr;
        logic       ferr;
        logic       bit8;
        logic [7:0] data;
    } urx_entry_t;

endpackage

// File: rtl/urx_deframer.sv
module urx_deframer
    import urx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       tick,
    input  logic       line,
    input  logic [3:0] nbits,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       two_stop,
    output logic       push,
    output urx_entry_t push_ent
);

    localparam int             CW      = $clog2(OSR);
    localparam logic [CW-1:0]  SMP_A   = CW'(OSR/2 - 1);
    localparam logic [CW-1:0]  SMP_B   = CW'(OSR/2);
    localparam logic [CW-1:0]  VOTE_AT = CW'(OSR/2 + 1);
    localparam logic [CW-1:0]  LAST    = CW'(OSR - 1);
    localparam logic [CW-1:0]  PENULT  = CW'(OSR - 2);

    urx_state_e    state, nxt;
    logic [CW-1:0] cnt;
    logic [3:0]    bidx;
    logic [1:0]    smp;
    logic          prev;
    logic [8:0]    shreg;
    logic          par_acc;
    logic          perr_r;
    logic          vote;
    logic          at_vote;
    logic          at_end;
    logic          fall;
    logic [8:0]    aligned;

    // Three-sample majority: two stored samples plus the line at the vote tick
    assign vote    = (smp[0] & smp[1]) | (smp[0] & line) | (smp[1] & line);
    assign at_vote = tick && (cnt == VOTE_AT);
    assign at_end  = tick && (cnt == LAST);
    assign fall    = tick && !line && prev;
    assign aligned = shreg >> (4'd9 - nbits);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (!en) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (fall) nxt = ST_START;
                ST_START: begin
                    if (at_vote && vote) nxt = ST_IDLE;
                    else if (at_end)     nxt = ST_DATA;
                end
                ST_DATA:  if (at_end && bidx == nbits - 4'd1)
                              nxt = par_en ? ST_PAR : ST_STOP;
                ST_PAR:   if (at_end) nxt = ST_STOP;
                ST_STOP:  if (at_vote) nxt = two_stop ? ST_SKIP : ST_IDLE;
                ST_SKIP:  if (tick && bidx[0] && cnt == PENULT) nxt = ST_IDLE;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            bidx     <= '0;
            smp      <= '0;
            prev     <= 1'b1;
            shreg    <= '0;
            par_acc  <= 1'b0;
            perr_r   <= 1'b0;
            push     <= 1'b0;
            push_ent <= '0;
        end else begin
            push <= 1'b0;
            if (tick) begin
                prev <= line;
                if (state == ST_IDLE) cnt <= '0;
                else                  cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
                if (cnt == SMP_A) smp[0] <= line;
                if (cnt == SMP_B) smp[1] <= line;
            end
            if (en) begin
                unique case (state)
                    ST_IDLE: if (fall) begin
                        shreg   <= '0;
                        bidx    <= '0;
                        par_acc <= 1'b0;
                        perr_r  <= 1'b0;
                    end
                    ST_DATA: begin
                        if (at_vote) begin
                            shreg   <= {vote, shreg[8:1]};
                            par_acc <= par_acc ^ vote;
                        end
                        if (at_end) bidx <= bidx + 4'd1;
                    end
                    ST_PAR:  if (at_vote) perr_r <= par_acc ^ vote ^ par_odd;
                    ST_STOP: if (at_vote) begin
                        push          <= 1'b1;
                        push_ent.data <= aligned[7:0];
                        push_ent.bit8 <= (nbits == 4'd9) ? aligned[8] : 1'b0;
                        push_ent.ferr <= !vote;
                        push_ent.perr <= perr_r;
                        push_ent.ovr  <= 1'b0;
                        bidx          <= '0;
                    end
                    ST_SKIP: if (at_end) bidx <= 4'd1;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/urx_status_fifo.sv
module urx_status_fifo
    import urx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  urx_entry_t push_ent,
    input  logic       pop,
    output logic       avail,
    output urx_entry_t head
);

    localparam int PW   = $clog2(DEPTH);
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0]   PMAX = PW'(DEPTH - 1);
    localparam logic [CNTW-1:0] FULL = CNTW'(DEPTH);

    urx_entry_t      mem [DEPTH];
    logic [PW-1:0]   wr_ptr, rd_ptr, newest;
    logic [CNTW-1:0] count;
    logic            do_pop, do_push, overrun;

    assign do_pop  = pop && (count != '0);
    assign do_push = push && ((count != FULL) || do_pop);
    assign overrun = push && !do_push;
    assign newest  = (wr_ptr == '0) ? PMAX : wr_ptr - 1'b1;
    assign avail   = (count != '0);
    assign head    = avail ? mem[rd_ptr] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= push_ent;
                wr_ptr      <= (wr_ptr == PMAX) ? '0 : wr_ptr + 1'b1;
            end
            if (overrun) mem[newest].ovr <= 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PMAX) ? '0 : rd_ptr + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/uart_rx_buffered.sv
module uart_rx_buffered
    import urx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_en,
    input  logic       baud_tick,
    input  logic       rx_line,
    input  logic [2:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_two_stop,
    input  logic       rd_pop,
    output logic       rx_avail,
    output logic [7:0] rx_data,
    output logic       rx_bit8,
    output logic       rx_ferr,
    output logic       rx_perr,
    output logic       rx_ovr
);

    logic       fr_push;
    urx_entry_t fr_ent;
    urx_entry_t hd;
    logic [3:0] nbits;

    // Codes 0..3 give 5..8 bits; any code with the top bit set gives 9
    assign nbits = cfg_len[2] ? 4'd9 : 4'd5 + {2'b00, cfg_len[1:0]};

    urx_deframer #(.OSR(OSR)) u_deframer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (rx_en),
        .tick     (baud_tick),
        .line     (rx_line),
        .nbits    (nbits),
        .par_en   (cfg_par_en),
        .par_odd  (cfg_par_odd),
        .two_stop (cfg_two_stop),
        .push     (fr_push),
        .push_ent (fr_ent)
    );

    urx_status_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (fr_push),
        .push_ent (fr_ent),
        .pop      (rd_pop),
        .avail    (rx_avail),
        .head     (hd)
    );

    assign rx_data = hd.data;
    assign rx_bit8 = hd.bit8;
    assign rx_ferr = hd.ferr;
    assign rx_perr = hd.perr;
    assign rx_ovr  = hd.ovr;

endmodule

// File: rtl/urx_checker.sv
module urx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic       rd_pop,
    input logic [2:0] cfg_len,
    input logic       cfg_par_en,
    input logic       rx_avail,
    input logic [7:0] rx_data,
    input logic       rx_bit8,
    input logic       rx_ferr,
    input logic       rx_perr,
    input logic       rx_ovr
);

    AST_EMPTY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_avail |-> (rx_data == 8'h00) && !rx_bit8 && !rx_ferr && !rx_perr && !rx_ovr); // R11

    AST_MASK_FIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_avail && (cfg_len == 3'd0) |-> (rx_data[7:5] == 3'b000)); // R4

    AST_BIT8_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rx_avail && !cfg_len[2] |-> !rx_bit8); // R5

    AST_PERR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        rx_avail && !cfg_par_en |-> !rx_perr); // R6

    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rx_avail && !rd_pop |=> rx_avail && $stable(rx_data) && $stable(rx_bit8)
                                && $stable(rx_ferr) && $stable(rx_perr) && $stable(rx_ovr)); // R9

    AST_IDLE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en && $past(!rx_en) && !rx_avail |=> !rx_avail); // R1

endmodule

bind uart_rx_buffered urx_checker u_chk (.*);

// File: tb/sim_uart_rx_buffered.sv
module sim_uart_rx_buffered;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       baud_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic [2:0] cfg_len = 3'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       rd_pop = 1'b0;
    logic       rx_avail;
    logic [7:0] rx_data;
    logic       rx_bit8, rx_ferr, rx_perr, rx_ovr;

    int checks = 0;
    int errors = 0;
    bit quiet = 1'b0;
    bit done = 1'b0;
    logic [11:0] q[$];   // {ovr, perr, ferr, bit8, data}

    always #5 clk = ~clk;

    uart_rx_buffered u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .baud_tick(baud_tick), .rx_line(rx_line),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .rd_pop(rd_pop), .rx_avail(rx_avail), .rx_data(rx_data),
        .rx_bit8(rx_bit8), .rx_ferr(rx_ferr), .rx_perr(rx_perr), .rx_ovr(rx_ovr)
    );

    function automatic logic [11:0] head_now();
        return {rx_ovr, rx_perr, rx_ferr, rx_bit8, rx_data};
    endfunction

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model compared every clock, outside the store window of a frame
    always @(posedge clk) begin
        #1;
        if (rst_n && !quiet && !done) begin
            check("R9 avail", {11'b0, rx_avail}, {11'b0, q.size() != 0});
            check("R9/R11 head", head_now(), (q.size() != 0) ? q[0] : 12'h000);
        end
    end

    task automatic bit_ticks(input logic v, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); rx_line = v; baud_tick = 1'b1;
            @(negedge clk); baud_tick = 1'b0;
        end
    endtask

    task automatic model_push(input logic [11:0] e);
        if (q.size() < 2) q.push_back(e);
        else q[q.size()-1][11] = 1'b1;  // R10 overrun marks newest
    endtask

    task automatic send_frame(input int nb, input logic [8:0] val, input logic pe, input logic po,
                              input logic ts, input logic flip, input logic s1, input logic s2,
                              input int drop_at);
        logic p;
        logic [8:0] m;
        logic [8:0] d;
        logic [11:0] e;
        @(negedge clk);
        cfg_len = (nb == 9) ? 3'd4 : 3'(nb - 5);
        cfg_par_en = pe; cfg_par_odd = po; cfg_two_stop = ts;
        bit_ticks(1'b0, 16);
        p = po;
        for (int i = 0; i < nb; i++) begin
            if (i == drop_at) rx_en = 1'b0;
            bit_ticks(val[i], 16);
            p ^= val[i];
        end
        if (pe) bit_ticks(p ^ flip, 16);
        bit_ticks(s1, 8);
        quiet = 1'b1;
        bit_ticks(s1, 5);
        m = (9'h1 << nb) - 9'h1;
        d = val & m;
        e = {1'b0, pe & flip, ~s1, d[8], d[7:0]};
        if (rx_en) model_push(e);
        quiet = 1'b0;
        bit_ticks(s1, 3);
        if (ts) bit_ticks(s2, 16);
        bit_ticks(1'b1, 4);
    endtask

    task automatic pop_expect(input logic [11:0] exp, input string tag);
        @(negedge clk);
        check(tag, {3'b0, rx_avail, 8'h00}, 12'h100);
        check(tag, head_now(), exp);
        rd_pop = 1'b1;
        @(posedge clk);
        if (q.size() != 0) void'(q.pop_front());
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    task automatic expect_empty(input string tag);
        @(negedge clk);
        check(tag, {11'b0, rx_avail}, 12'h000);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset", {3'b0, rx_avail, head_now()[7:0]}, 12'h000);
        check("R11 reset flags", head_now(), 12'h000);

        // R1: disabled receiver stores nothing
        send_frame(8, 9'h0A5, 0, 0, 0, 0, 1, 1, -1);
        expect_empty("R1 disabled");
        rx_en = 1'b1;
        bit_ticks(1'b1, 8);

        // R3: plain 8-bit frame
        send_frame(8, 9'h0A5, 0, 0, 0, 0, 1, 1, -1);
        pop_expect(12'h0A5, "R3 8bit");
        send_frame(6, 9'h02D, 0, 0, 0, 0, 1, 1, -1);
        pop_expect(12'h02D, "R3 6bit");

        // R4: 5-bit and 7-bit, upper bits masked
        send_frame(5, 9'h1F5, 0, 0, 0, 0, 1, 1, -1);
        pop_expect(12'h015, "R4 5bit");
        send_frame(7, 9'h1FF, 0, 0, 0, 0, 1, 1, -1);
        pop_expect(12'h07F, "R4 7bit");

        // R5: ninth bit
        send_frame(9, 9'h13C, 0, 0, 0, 0, 1, 1, -1);
        pop_expect(12'h13C, "R5 bit8 one");
        send_frame(9, 9'h0C3, 0, 0, 0, 0, 1, 1, -1);
        pop_expect(12'h0C3, "R5 bit8 zero");

        // R6: parity even/odd, good and bad
        send_frame(8, 9'h037, 1, 0, 0, 0, 1, 1, -1);
        pop_expect(12'h037, "R6 even good");
        send_frame(8, 9'h037, 1, 0, 0, 1, 1, 1, -1);
        pop_expect(12'h437, "R6 even bad");
        send_frame(7, 9'h055, 1, 1, 0, 0, 1, 1, -1);
        pop_expect(12'h055, "R6 odd good");
        send_frame(7, 9'h055, 1, 1, 0, 1, 1, 1, -1);
        pop_expect(12'h455, "R6 odd bad");

        // R7: low first stop bit
        send_frame(8, 9'h081, 0, 0, 0, 0, 0, 1, -1);
        bit_ticks(1'b1, 8);
        pop_expect(12'h281, "R7 ferr");

        // R8: second stop bit low is ignored
        send_frame(8, 9'h05A, 0, 0, 1, 0, 1, 0, -1);
        pop_expect(12'h05A, "R8 stop2 low");
        send_frame(8, 9'h0E1, 1, 1, 1, 0, 1, 1, -1);
        pop_expect(12'h0E1, "R8 two stop");

        // R2: short low glitch rejected
        @(negedge clk); cfg_len = 3'd3; cfg_par_en = 1'b0; cfg_two_stop = 1'b0;
        bit_ticks(1'b0, 4);
        bit_ticks(1'b1, 40);
        expect_empty("R2 glitch");
        send_frame(8, 9'h066, 0, 0, 0, 0, 1, 1, -1);
        pop_expect(12'h066, "R2 after glitch");

        // R9: pop on empty has no effect
        @(negedge clk); rd_pop = 1'b1;
        @(negedge clk); rd_pop = 1'b0;
        expect_empty("R9 pop empty");
        send_frame(8, 9'h011, 0, 0, 0, 0, 1, 1, -1);
        pop_expect(12'h011, "R9 after empty pop");

        // R10: three frames into a two-entry queue
        send_frame(8, 9'h0A1, 0, 0, 0, 0, 1, 1, -1);
        send_frame(8, 9'h0B2, 0, 0, 0, 0, 1, 1, -1);
        send_frame(8, 9'h0C3, 0, 0, 0, 0, 1, 1, -1);
        pop_expect(12'h0A1, "R10 first");
        pop_expect(12'h8B2, "R10 newest ovr");
        expect_empty("R10 third dropped");

        // R1: enable dropped mid-frame
        send_frame(8, 9'h0F0, 0, 0, 0, 0, 1, 1, 3);
        bit_ticks(1'b1, 20);
        expect_empty("R1 abort");
        rx_en = 1'b1;
        bit_ticks(1'b1, 20);
        send_frame(8, 9'h03C, 0, 0, 0, 0, 1, 1, -1);
        pop_expect(12'h03C, "R1 re-enabled");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule